// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit binary down-counter channel of the kind used in general purpose interval timers. A host-side interface (outside this block) presents a load strobe with a 16-bit initial value and a 3-bit mode number. The channel then counts on each cycle where the count-enable tick is high. It drives one output pin whose waveform depends on the mode: a terminal-count flag, a retriggerable one-shot, a periodic rate pulse, a square wave, or a single strobe pulse started by software or by hardware. The live count is always visible on an output port, so the host interface can capture it.

The gate input can pause counting or retrigger the channel, depending on the mode. An initial value of zero stands for 65536. Everything is synchronous to `clk`. The count advances only on cycles where `countTick` is high, so the counting rate is set by whoever drives the tick.

Top module: `ictr_channel`

## Requirements
- R1: A synchronous active-high `rst` sets `outPin` high and `liveCount` to 0. After reset and before the first load, neither ticks nor gate activity changes either output.
- R2: A cycle with `loadStrobe` high sets `liveCount` to `loadValue` in the next cycle, whatever the mode and whatever the count was doing. Load takes priority over gate and tick. A loaded value of 0 means 65536: one tick after loading 0 in a mode with a single-step decrement, `liveCount` reads 0xFFFF.
- R3: Mode 0 (terminal count): the output goes low on load. Each tick with gate high decrements the count by one. The output goes high on the tick that brings the count to 0 and stays high until the next load. The count keeps wrapping modulo 65536 afterwards, with no reload.
- R4: Mode 1 (hardware one-shot): the output is high after load. A gate rising edge reloads the initial value and drives the output low. The output returns high on the tick that brings the count to 0. Every tick decrements by one, and the count wraps without reloading.
- R5: Mode 2 (rate generator): while gate is high, each tick decrements by one. When a tick finds the count at 1, the initial value is reloaded. The output is low exactly while the count reads 1 and high otherwise.
- R6: Mode 3 (square wave): while gate is high, each tick decrements by two. When a tick finds the count at 1 or 2, the initial value is reloaded and the output toggles. The output starts high after a load.
- R7: Mode 4 (software strobe): the output is high after load. Every tick decrements by one, regardless of gate. The output is low for exactly one tick interval after the first time the count reaches 0, and it does not go low again until reloaded.
- R8: Mode 5 (hardware strobe): like mode 4, but the single low pulse is armed only by a gate rising edge. That edge also reloads the initial value. The output is high after load and after each edge.
- R9: While gate is low, counting is held in modes 0, 2 and 3, and in modes 2 and 3 the output is forced high. In mode 4 the gate has no effect.
- R10: A gate rising edge is a cycle with gate high whose previous cycle had gate low (a reset counts as high). Such an edge reloads the initial value in modes 1, 2, 3 and 5 and has no effect on the count in modes 0 and 4.
- R11: Mode numbers 6 and 7 behave exactly as modes 2 and 3.
- R12: In a cycle with `countTick` low and no load and no gate rising edge, `liveCount` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| countTick | input | 1 | Count enable, one counting step per high cycle |
| gate | input | 1 | Gate level: enable, or trigger on its rising edge |
| loadStrobe | input | 1 | Load a new initial value and mode |
| loadMode | input | 3 | Counting mode captured with the load |
| loadValue | input | 16 | Initial count captured with the load (0 = 65536) |
| outPin | output | 1 | Channel output waveform |
| liveCount | output | 16 | Current counter value |

## Verification
Each mode is run with an unbroken tick stream, which shows the basic waveform, reload point and period. A sparse tick pattern then separates tick counting from clock counting. Gate drops and rising edges are placed in the middle of a count, which tells the pausing modes from the retriggering modes and from the modes where gate does nothing. A load of zero and small initial values of 1 to 5 stress the wrap, the odd half-periods and the reload boundaries. A pseudo-random mix of ticks, gate and reloads across all eight mode numbers checks that the aliased modes behave exactly like their originals.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_TERM     = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } chanMode_e;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic loadNew;
    logic reload;
    logic dec1;
    logic dec2;
  } dpStrobe_t;

  // Mode numbers 6 and 7 fold onto rate generator and square wave.
  function automatic chanMode_e foldMode(input logic [MODE_W-1:0] raw);
    case (raw)
      3'd6:    foldMode = MODE_RATE;
      3'd7:    foldMode = MODE_SQUARE;
      default: foldMode = chanMode_e'(raw);
    endcase
  endfunction

endpackage

// File: rtl/ictr_datapath.sv
module ictr_datapath
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] cnt,
  output logic             cntIsOne,
  output logic             cntIsTwo,
  output logic             initIsOne
);

  localparam logic [CNT_W-1:0] STEP_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] STEP_TWO = CNT_W'(2);

  logic [CNT_W-1:0] initReg;
  logic [CNT_W-1:0] cntReg;

  // A stored zero naturally acts as 2^CNT_W under modulo arithmetic.
  always_ff @(posedge clk) begin
    if (rst) begin
      initReg <= '0;
      cntReg  <= '0;
    end else if (stb.loadNew) begin
      initReg <= loadValue;
      cntReg  <= loadValue;
    end else if (stb.reload) begin
      cntReg <= initReg;
    end else if (stb.dec1) begin
      cntReg <= cntReg - STEP_ONE;
    end else if (stb.dec2) begin
      cntReg <= cntReg - STEP_TWO;
    end
  end

  assign cnt       = cntReg;
  assign cntIsOne  = (cntReg == STEP_ONE);
  assign cntIsTwo  = (cntReg == STEP_TWO);
  assign initIsOne = (initReg == STEP_ONE);

endmodule

// File: rtl/ictr_control.sv
module ictr_control
  import ictr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              countTick,
  input  logic              gate,
  input  logic              loadStrobe,
  input  logic [MODE_W-1:0] loadMode,
  input  logic              cntIsOne,
  input  logic              cntIsTwo,
  input  logic              initIsOne,
  output dpStrobe_t         stb,
  output logic              outPin
);

  chanMode_e modeReg, modeNext, newMode;
  logic      running, runNext;
  logic      armed, armedNext;
  logic      outReg, outNext;
  logic      gatePrev;
  logic      gateRise;

  assign newMode  = foldMode(loadMode);
  assign gateRise = gate & ~gatePrev;

  always_comb begin
    stb       = '0;
    modeNext  = modeReg;
    runNext   = running;
    armedNext = armed;
    outNext   = outReg;
    if (loadStrobe) begin
      stb.loadNew = 1'b1;
      modeNext    = newMode;
      runNext     = 1'b1;
      armedNext   = (newMode == MODE_TERM) || (newMode == MODE_SWSTROBE);
      outNext     = (newMode != MODE_TERM);
    end else if (running) begin
      case (modeReg)
        MODE_TERM: begin
          if (countTick && gate) begin
            stb.dec1 = 1'b1;
            if (armed && cntIsOne) begin
              outNext   = 1'b1;
              armedNext = 1'b0;
            end
          end
        end
        MODE_SWSTROBE: begin
          if (countTick) begin
            stb.dec1 = 1'b1;
            if (armed && cntIsOne) begin
              outNext   = 1'b0;
              armedNext = 1'b0;
            end else begin
              outNext = 1'b1;
            end
          end
        end
        MODE_ONESHOT: begin
          if (gateRise) begin
            stb.reload = 1'b1;
            outNext    = 1'b0;
            armedNext  = 1'b1;
          end else if (countTick) begin
            stb.dec1 = 1'b1;
            if (armed && cntIsOne) begin
              outNext   = 1'b1;
              armedNext = 1'b0;
            end
          end
        end
        MODE_HWSTROBE: begin
          if (gateRise) begin
            stb.reload = 1'b1;
            outNext    = 1'b1;
            armedNext  = 1'b1;
          end else if (countTick) begin
            stb.dec1 = 1'b1;
            if (armed && cntIsOne) begin
              outNext   = 1'b0;
              armedNext = 1'b0;
            end else begin
              outNext = 1'b1;
            end
          end
        end
        MODE_RATE: begin
          if (gateRise) begin
            stb.reload = 1'b1;
            outNext    = 1'b1;
          end else if (!gate) begin
            outNext = 1'b1;
          end else if (countTick) begin
            if (cntIsOne) begin
              stb.reload = 1'b1;
              outNext    = !initIsOne;
            end else begin
              stb.dec1 = 1'b1;
              outNext  = !cntIsTwo;
            end
          end
        end
        MODE_SQUARE: begin
          if (gateRise) begin
            stb.reload = 1'b1;
            outNext    = 1'b1;
          end else if (!gate) begin
            outNext = 1'b1;
          end else if (countTick) begin
            if (cntIsOne || cntIsTwo) begin
              stb.reload = 1'b1;
              outNext    = !outReg;
            end else begin
              stb.dec2 = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg  <= MODE_TERM;
      running  <= 1'b0;
      armed    <= 1'b0;
      outReg   <= 1'b1;
      gatePrev <= 1'b1;
    end else begin
      modeReg  <= modeNext;
      running  <= runNext;
      armed    <= armedNext;
      outReg   <= outNext;
      gatePrev <= gate;
    end
  end

  assign outPin = outReg;

endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
  import ictr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              countTick,
  input  logic              gate,
  input  logic              loadStrobe,
  input  logic [MODE_W-1:0] loadMode,
  input  logic [CNT_W-1:0]  loadValue,
  output logic              outPin,
  output logic [CNT_W-1:0]  liveCount
);

  dpStrobe_t stb;
  logic      cntIsOne;
  logic      cntIsTwo;
  logic      initIsOne;

  ictr_control u_ctl (
    .clk        (clk),
    .rst        (rst),
    .countTick  (countTick),
    .gate       (gate),
    .loadStrobe (loadStrobe),
    .loadMode   (loadMode),
    .cntIsOne   (cntIsOne),
    .cntIsTwo   (cntIsTwo),
    .initIsOne  (initIsOne),
    .stb        (stb),
    .outPin     (outPin)
  );

  ictr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .loadValue (loadValue),
    .cnt       (liveCount),
    .cntIsOne  (cntIsOne),
    .cntIsTwo  (cntIsTwo),
    .initIsOne (initIsOne)
  );

endmodule

// File: rtl/ictr_checker.sv
module ictr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             countTick,
  input logic             gate,
  input logic             loadStrobe,
  input logic [2:0]       loadMode,
  input logic [CNT_W-1:0] loadValue,
  input logic             outPin,
  input logic [CNT_W-1:0] liveCount
);

  // Independent record of the last loaded mode number.
  logic [2:0] lastMode;
  logic       loaded;
  always_ff @(posedge clk) begin
    if (rst) begin
      lastMode <= 3'd0;
      loaded   <= 1'b0;
    end else if (loadStrobe) begin
      lastMode <= loadMode;
      loaded   <= 1'b1;
    end
  end

  logic gatedWave;
  assign gatedWave = loaded && (lastMode[1:0] == 2'd2 || lastMode[1:0] == 2'd3) && lastMode != 3'd6
                     ? 1'b1 : (loaded && (lastMode == 3'd6 || lastMode == 3'd7));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (outPin && liveCount == '0));

  assert_idle_before_load_R1: assert property (@(posedge clk) disable iff (rst)
    (!loaded && !loadStrobe) |=> (liveCount == '0 && outPin));

  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    loadStrobe |=> (liveCount == $past(loadValue)));

  assert_term_low_on_load_R3: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && loadMode == 3'd0) |=> !outPin);

  assert_hwstrobe_high_on_load_R8: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && loadMode == 3'd5) |=> outPin);

  assert_gate_low_forces_high_R9: assert property (@(posedge clk) disable iff (rst)
    (gatedWave && !gate && !loadStrobe) |=> outPin);

  assert_hold_without_tick_R12: assert property (@(posedge clk) disable iff (rst)
    (!countTick && !loadStrobe && $stable(gate)) |=> $stable(liveCount));

endmodule

bind ictr_channel ictr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .countTick  (countTick),
  .gate       (gate),
  .loadStrobe (loadStrobe),
  .loadMode   (loadMode),
  .loadValue  (loadValue),
  .outPin     (outPin),
  .liveCount  (liveCount)
);

// File: tb/ictr_channel_tb.sv
module ictr_channel_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        countTick = 1'b0;
  logic        gate = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [2:0]  loadMode = 3'd0;
  logic [15:0] loadValue = 16'd0;
  logic        outPin;
  logic [15:0] liveCount;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ictr_channel u_dut (
    .clk(clk), .rst(rst), .countTick(countTick), .gate(gate),
    .loadStrobe(loadStrobe), .loadMode(loadMode), .loadValue(loadValue),
    .outPin(outPin), .liveCount(liveCount)
  );

  // Behavioural reference model
  int mMode, mCnt, mInit, mOut, mArmed, mRun, mGPrev;

  function automatic int fold(input int m);
    return (m == 6) ? 2 : (m == 7) ? 3 : m;
  endfunction

  function automatic string tagOf(input int m);
    case (fold(m))
      0: return "R3"; 1: return "R4"; 2: return "R5";
      3: return "R6"; 4: return "R7"; default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mMode = 0; mCnt = 0; mInit = 65536; mOut = 1; mArmed = 0; mRun = 0; mGPrev = 1;
    end else begin
      int rise;
      int m;
      rise = (gate && !mGPrev) ? 1 : 0;
      mGPrev = gate;
      m = fold(mMode);
      if (loadStrobe) begin
        mMode = loadMode;
        mInit = (loadValue == 0) ? 65536 : loadValue;
        mCnt = mInit;
        mRun = 1;
        mArmed = (fold(loadMode) == 0 || fold(loadMode) == 4) ? 1 : 0;
        mOut = (fold(loadMode) == 0) ? 0 : 1;
      end else if (mRun == 1) begin
        if ((m == 1 || m == 2 || m == 3 || m == 5) && rise == 1) begin
          mCnt = mInit;
          mOut = (m == 1) ? 0 : 1;
          if (m == 1 || m == 5) mArmed = 1;
        end else if ((m == 2 || m == 3) && !gate) begin
          mOut = 1;
        end else if (countTick && (m != 0 || gate)) begin
          if (m == 2) begin
            mCnt = (mCnt == 1) ? mInit : mCnt - 1;
            mOut = (mCnt == 1) ? 0 : 1;
          end else if (m == 3) begin
            if (mCnt <= 2) begin mCnt = mInit; mOut = 1 - mOut; end
            else mCnt = mCnt - 2;
          end else begin
            mCnt = (mCnt == 0) ? 65535 : mCnt - 1;
            if (m == 4 || m == 5) mOut = 1;
            if (mArmed == 1 && mCnt == 0) begin
              mArmed = 0;
              mOut = (m == 0 || m == 1) ? 1 : 0;
            end
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(outPin == mOut[0], tagOf(mMode), outPin, mOut);
      chk(liveCount == mCnt[15:0], tagOf(mMode), liveCount, mCnt % 65536);
    end
  end

  task automatic cyc(input bit t, input bit g);
    countTick = t; gate = g;
    @(negedge clk);
  endtask

  task automatic load(input int m, input int v, input bit g);
    loadStrobe = 1'b1; loadMode = m[2:0]; loadValue = v[15:0];
    countTick = 1'b0; gate = g;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; failures++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(outPin == 1'b1, "R1 reset out", outPin, 1);
    chk(liveCount == 16'd0, "R1 reset count", liveCount, 0);
    repeat (4) cyc(1, 1);
    cyc(1, 0); cyc(1, 1);
    chk(liveCount == 16'd0 && outPin, "R1 idle before load", liveCount, 0);

    // R3 terminal count with wrap
    load(0, 3, 1);
    chk(liveCount == 16'd3, "R2 load value", liveCount, 3);
    chk(outPin == 1'b0, "R3 low on load", outPin, 0);
    repeat (3) cyc(1, 1);
    chk(outPin == 1'b1, "R3 high at zero", outPin, 1);
    repeat (2) cyc(1, 1);
    chk(liveCount == 16'hFFFE, "R3 wrap", liveCount, 16'hFFFE);

    // R9 mode 0 holds while gate low; R10 no restart on edge
    load(0, 5, 1);
    repeat (2) cyc(1, 1);
    repeat (3) cyc(1, 0);
    chk(liveCount == 16'd3, "R9 mode0 hold", liveCount, 3);
    cyc(0, 1);
    chk(liveCount == 16'd3, "R10 mode0 no restart", liveCount, 3);

    // R7 software strobe, gate ignored
    load(4, 2, 0);
    cyc(1, 0);
    cyc(1, 0);
    chk(outPin == 1'b0, "R7 strobe low", outPin, 0);
    chk(liveCount == 16'd0, "R9 mode4 ignores gate", liveCount, 0);
    cyc(1, 0);
    chk(outPin == 1'b1, "R7 strobe one tick", outPin, 1);

    // R2 zero means 65536
    load(4, 0, 1);
    chk(liveCount == 16'd0, "R2 zero loaded", liveCount, 0);
    cyc(1, 1);
    chk(liveCount == 16'hFFFF, "R2 zero as 65536", liveCount, 16'hFFFF);

    // R4 one-shot and R10 retrigger
    load(1, 3, 0);
    chk(outPin == 1'b1, "R4 high after load", outPin, 1);
    cyc(0, 1);
    chk(liveCount == 16'd3 && !outPin, "R4 trigger", liveCount, 3);
    cyc(1, 1);
    cyc(0, 0);
    cyc(0, 1);
    chk(liveCount == 16'd3, "R10 retrigger", liveCount, 3);
    repeat (3) cyc(1, 1);
    chk(outPin == 1'b1, "R4 end of shot", outPin, 1);

    // R5 rate generator
    load(2, 3, 1);
    cyc(1, 1);
    chk(outPin == 1'b1, "R5 high at 2", outPin, 1);
    cyc(1, 1);
    chk(outPin == 1'b0, "R5 low at 1", outPin, 0);
    cyc(1, 1);
    chk(liveCount == 16'd3 && outPin, "R5 reload", liveCount, 3);
    cyc(1, 1); cyc(1, 0);
    chk(outPin == 1'b1 && liveCount == 16'd2, "R9 rate gate low", liveCount, 2);

    // R6 square wave
    load(3, 4, 1);
    repeat (2) cyc(1, 1);
    chk(outPin == 1'b0 && liveCount == 16'd4, "R6 first toggle", outPin, 0);
    repeat (2) cyc(1, 1);
    chk(outPin == 1'b1, "R6 second toggle", outPin, 1);
    cyc(0, 1);
    chk(liveCount == 16'd4, "R12 no tick hold", liveCount, 4);

    // R8 hardware strobe
    load(5, 2, 0);
    cyc(0, 1);
    cyc(1, 1);
    cyc(1, 1);
    chk(outPin == 1'b0, "R8 strobe low", outPin, 0);
    cyc(1, 1);
    chk(outPin == 1'b1, "R8 strobe ends", outPin, 1);

    // R11 aliases
    load(6, 3, 1);
    repeat (2) cyc(1, 1);
    chk(outPin == 1'b0, "R11 mode6 as rate", outPin, 0);
    load(7, 4, 1);
    repeat (2) cyc(1, 1);
    chk(outPin == 1'b0, "R11 mode7 as square", outPin, 0);

    // Mixed pseudo-random phase over all mode numbers (model compare)
    lfsr = 16'hACE1;
    for (int m = 0; m < 8; m++) begin
      for (int rep = 0; rep < 3; rep++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        load(m, lfsr % 6, lfsr[7]);
        for (int c = 0; c < 40; c++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          cyc(lfsr[0] | lfsr[1], lfsr[2] | lfsr[3] | lfsr[4]);
        end
      end
    end

    finish_run();
  end

endmodule